// File: doc/BRIEF.md
# Scaler phase increment calculator

This block turns one scaling configuration into the stepping values that a polyphase resampler needs. It takes the source and destination width and height, a source and a destination sampling format and a chroma siting code. From them it works out four phase increments: luma horizontal, luma vertical, chroma horizontal and chroma vertical. Each increment is an unsigned value with 13 fractional bits. The block also produces two signed chroma start offsets in the same 13-bit phase-fraction units. For each start offset it gives the 4-bit filter phase index.

A single shared restoring divider computes the four quotients one after another, one quotient bit per cycle. A start request is accepted only while the block is idle. When all four results are ready, the result registers update together and `valid_o` pulses for one cycle. The results then hold until the next computation completes. A configuration that would divide by zero raises `err_o` instead of `valid_o`.

Top module: `scl_phase_calc`

## Requirements
- R1: Each increment equals floor((src·8192 + floor(dst/2)) / dst) for its source/destination pair. Luma uses the raw dimensions. Chroma uses the derived chroma dimensions of R3.
- R2: An increment whose exact quotient exceeds 65535 is reported as 65535 (0xFFFF).
- R3: Format codes are 0 = 4:2:0, 1 = 4:2:2, 2 = 4:4:4/RGB, and code 3 behaves as code 2. Source chroma width is floor(src_w/2) for codes 0 and 1. Source chroma height is floor(src_h/2) for code 0 only. Destination chroma width is floor(dst_w/2) for destination code 1 only. Destination chroma height always equals dst_h.
- R4: For a 4:2:0 source, the chroma vertical start is −2048 for siting codes 0 and 1, and −4096 for codes 4 and 5. It is 0 for every other case, including every non-4:2:0 source.
- R5: For a 4:2:0 source, the chroma horizontal start is −2048 for siting codes 1, 3 and 5. It is 0 otherwise, including every non-4:2:0 source.
- R6: Each phase index output equals bits [12:9] of its 16-bit two's-complement start value. This gives 12 for −2048, 8 for −4096 and 0 for 0.
- R7: A destination width, destination height or derived destination chroma width of zero drives `err_o` high with no `valid_o`. The previous results stay on the outputs. `err_o` stays high until the next accepted start clears it.
- R8: `valid_o` is a one-cycle pulse, and `busy_o` falls in that same cycle. Completion comes no more than 115 clock cycles after the start cycle with default parameters.
- R9: Result outputs change only in a cycle where `valid_o` is high, and otherwise hold their values.
- R10: A start request while `busy_o` is high is ignored, and the running computation finishes with its original configuration.
- R11: After reset, `busy_o`, `valid_o` and `err_o` are low and every result output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken when idle |
| src_w_i | input | 12 | Source width |
| src_h_i | input | 12 | Source height |
| dst_w_i | input | 12 | Destination width |
| dst_h_i | input | 12 | Destination height |
| src_fmt_i | input | 2 | Source sampling format code |
| dst_fmt_i | input | 2 | Destination sampling format code |
| siting_i | input | 3 | Chroma siting code (0..5 defined) |
| busy_o | output | 1 | Computation in progress |
| valid_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Zero divisor in last accepted configuration |
| luma_hinc_o | output | 16 | Luma horizontal increment |
| luma_vinc_o | output | 16 | Luma vertical increment |
| chroma_hinc_o | output | 16 | Chroma horizontal increment |
| chroma_vinc_o | output | 16 | Chroma vertical increment |
| chroma_hstart_o | output | 16 | Signed chroma horizontal start |
| chroma_vstart_o | output | 16 | Signed chroma vertical start |
| chroma_hphase_o | output | 4 | Phase index of horizontal start |
| chroma_vphase_o | output | 4 | Phase index of vertical start |

## Verification
The bench sweeps every combination of source format, destination format and siting code, including the undefined codes. A design that applied the siting offsets to a non-4:2:0 source, or halved the wrong chroma dimension, would miscompare there. A dimension sweep takes in ratios of exactly 8:1 and above to reach the saturation point, and unit dimensions to reach odd rounding; an off-by-one in the divider's bit count or a wrapped quotient shows up there. Zero destination sizes, including a 4:2:2 destination one pixel wide, must raise the error while leaving the old results in place. A second start issued mid-computation must not disturb the running result.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam logic [1:0] FMT_420 = 2'd0;
  localparam logic [1:0] FMT_422 = 2'd1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_KICK,
    ST_WAIT
  } calc_st_e;
endpackage

// File: rtl/scl_chroma_geom.sv
module scl_chroma_geom
  import scl_pkg::*;
#(
  parameter int DIM_W     = 12,
  parameter int START_W   = 16,
  parameter int FRAC_BITS = 13
) (
  input  logic [DIM_W-1:0]          src_w_i,
  input  logic [DIM_W-1:0]          src_h_i,
  input  logic [DIM_W-1:0]          dst_w_i,
  input  logic [DIM_W-1:0]          dst_h_i,
  input  logic [1:0]                src_fmt_i,
  input  logic [1:0]                dst_fmt_i,
  input  logic [2:0]                siting_i,
  output logic [DIM_W-1:0]          src_cw_o,
  output logic [DIM_W-1:0]          src_ch_o,
  output logic [DIM_W-1:0]          dst_cw_o,
  output logic [DIM_W-1:0]          dst_ch_o,
  output logic signed [START_W-1:0] hstart_o,
  output logic signed [START_W-1:0] vstart_o
);
  localparam logic signed [START_W-1:0] QTR  = START_W'(1 << (FRAC_BITS - 2));
  localparam logic signed [START_W-1:0] HALF = START_W'(1 << (FRAC_BITS - 1));

  logic src_sub_h, src_sub_v, dst_sub_h;

  always_comb begin
    src_sub_h = (src_fmt_i == FMT_420) || (src_fmt_i == FMT_422);
    src_sub_v = (src_fmt_i == FMT_420);
    dst_sub_h = (dst_fmt_i == FMT_422);
    src_cw_o  = src_sub_h ? (src_w_i >> 1) : src_w_i;
    src_ch_o  = src_sub_v ? (src_h_i >> 1) : src_h_i;
    dst_cw_o  = dst_sub_h ? (dst_w_i >> 1) : dst_w_i;
    dst_ch_o  = dst_h_i;
  end

  // siting offsets apply to vertically and horizontally subsampled sources only
  always_comb begin
    vstart_o = '0;
    hstart_o = '0;
    if (src_sub_v) begin
      unique case (siting_i)
        3'd0, 3'd1: vstart_o = -QTR;
        3'd4, 3'd5: vstart_o = -HALF;
        default:    vstart_o = '0;
      endcase
      unique case (siting_i)
        3'd1, 3'd3, 3'd5: hstart_o = -QTR;
        default:          hstart_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/scl_div_iter.sv
module scl_div_iter #(
  parameter int NUM_W = 25,
  parameter int DEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] q_q;
  logic [DEN_W-1:0] r_q, d_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q;
  logic [DEN_W:0]   r_sh, r_nx;
  logic             ge;

  always_comb begin
    r_sh = {r_q, q_q[NUM_W-1]};
    ge   = r_sh >= {1'b0, d_q};
    r_nx = ge ? (r_sh - {1'b0, d_q}) : r_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= '0;
      r_q    <= '0;
      d_q    <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        q_q   <= num_i;
        r_q   <= '0;
        d_q   <= den_i;
        cnt_q <= CNT_W'(NUM_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        q_q   <= {q_q[NUM_W-2:0], ge};
        r_q   <= r_nx[DEN_W-1:0];
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = q_q;
endmodule

// File: rtl/scl_phase_calc.sv
module scl_phase_calc
  import scl_pkg::*;
#(
  parameter int DIM_W      = 12,
  parameter int INC_W      = 16,
  parameter int START_W    = 16,
  parameter int FRAC_BITS  = 13,
  parameter int PHASE_BITS = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [DIM_W-1:0]          src_w_i,
  input  logic [DIM_W-1:0]          src_h_i,
  input  logic [DIM_W-1:0]          dst_w_i,
  input  logic [DIM_W-1:0]          dst_h_i,
  input  logic [1:0]                src_fmt_i,
  input  logic [1:0]                dst_fmt_i,
  input  logic [2:0]                siting_i,
  output logic                      busy_o,
  output logic                      valid_o,
  output logic                      err_o,
  output logic [INC_W-1:0]          luma_hinc_o,
  output logic [INC_W-1:0]          luma_vinc_o,
  output logic [INC_W-1:0]          chroma_hinc_o,
  output logic [INC_W-1:0]          chroma_vinc_o,
  output logic signed [START_W-1:0] chroma_hstart_o,
  output logic signed [START_W-1:0] chroma_vstart_o,
  output logic [PHASE_BITS-1:0]     chroma_hphase_o,
  output logic [PHASE_BITS-1:0]     chroma_vphase_o
);
  localparam int NUM_W = DIM_W + FRAC_BITS;
  localparam int NJOBS = 4;
  localparam int JOB_W = $clog2(NJOBS);
  localparam logic [JOB_W-1:0] LAST_JOB = JOB_W'(NJOBS - 1);

  calc_st_e st_q;
  logic [JOB_W-1:0] job_q;
  logic [DIM_W-1:0] sw_q, sh_q, dw_q, dh_q;
  logic [1:0]       sf_q, df_q;
  logic [2:0]       sit_q;
  logic             valid_q, err_q;

  logic [DIM_W-1:0] scw, sch, dcw, dch;
  logic signed [START_W-1:0] hst, vst, hst_q, vst_q;

  logic [DIM_W-1:0] job_src [NJOBS];
  logic [DIM_W-1:0] job_dst [NJOBS];
  logic [NJOBS-1:0] dst_zero;
  logic [INC_W-1:0] res_q [NJOBS];
  logic [INC_W-1:0] out_q [NJOBS];

  logic             div_go, div_done, fin;
  logic [DIM_W-1:0] cur_src, cur_dst;
  logic [NUM_W-1:0] div_num, div_quo;
  logic [INC_W-1:0] quo_sat;

  scl_chroma_geom #(
    .DIM_W    (DIM_W),
    .START_W  (START_W),
    .FRAC_BITS(FRAC_BITS)
  ) i_geom (
    .src_w_i  (sw_q),
    .src_h_i  (sh_q),
    .dst_w_i  (dw_q),
    .dst_h_i  (dh_q),
    .src_fmt_i(sf_q),
    .dst_fmt_i(df_q),
    .siting_i (sit_q),
    .src_cw_o (scw),
    .src_ch_o (sch),
    .dst_cw_o (dcw),
    .dst_ch_o (dch),
    .hstart_o (hst),
    .vstart_o (vst)
  );

  // job order: luma h, luma v, chroma h, chroma v
  assign job_src[0] = sw_q;
  assign job_dst[0] = dw_q;
  assign job_src[1] = sh_q;
  assign job_dst[1] = dh_q;
  assign job_src[2] = scw;
  assign job_dst[2] = dcw;
  assign job_src[3] = sch;
  assign job_dst[3] = dch;

  for (genvar j = 0; j < NJOBS; j++) begin : g_zero
    assign dst_zero[j] = (job_dst[j] == '0);
  end

  assign cur_src = job_src[job_q];
  assign cur_dst = job_dst[job_q];
  assign div_num = {cur_src, {FRAC_BITS{1'b0}}} + NUM_W'(cur_dst >> 1);
  assign div_go  = (st_q == ST_KICK);

  scl_div_iter #(
    .NUM_W(NUM_W),
    .DEN_W(DIM_W)
  ) i_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (div_go),
    .num_i (div_num),
    .den_i (cur_dst),
    .done_o(div_done),
    .quo_o (div_quo)
  );

  // requires NUM_W > INC_W
  assign quo_sat = (|div_quo[NUM_W-1:INC_W]) ? {INC_W{1'b1}} : div_quo[INC_W-1:0];
  assign fin     = (st_q == ST_WAIT) && div_done && (job_q == LAST_JOB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      job_q   <= '0;
      sw_q    <= '0;
      sh_q    <= '0;
      dw_q    <= '0;
      dh_q    <= '0;
      sf_q    <= '0;
      df_q    <= '0;
      sit_q   <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            sw_q  <= src_w_i;
            sh_q  <= src_h_i;
            dw_q  <= dst_w_i;
            dh_q  <= dst_h_i;
            sf_q  <= src_fmt_i;
            df_q  <= dst_fmt_i;
            sit_q <= siting_i;
            err_q <= 1'b0;
            st_q  <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          job_q <= '0;
          if (|dst_zero) begin
            err_q <= 1'b1;
            st_q  <= ST_IDLE;
          end else begin
            st_q <= ST_KICK;
          end
        end
        ST_KICK: st_q <= ST_WAIT;
        ST_WAIT: begin
          if (div_done) begin
            if (job_q == LAST_JOB) begin
              valid_q <= 1'b1;
              st_q    <= ST_IDLE;
            end else begin
              job_q <= job_q + 1'b1;
              st_q  <= ST_KICK;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < NJOBS; j++) res_q[j] <= '0;
    end else if ((st_q == ST_WAIT) && div_done) begin
      for (int j = 0; j < NJOBS; j++)
        if (job_q == JOB_W'(j)) res_q[j] <= quo_sat;
    end
  end

  // all results publish together on completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < NJOBS; j++) out_q[j] <= '0;
      hst_q <= '0;
      vst_q <= '0;
    end else if (fin) begin
      for (int j = 0; j < NJOBS - 1; j++) out_q[j] <= res_q[j];
      out_q[NJOBS-1] <= quo_sat;
      hst_q <= hst;
      vst_q <= vst;
    end
  end

  assign busy_o          = (st_q != ST_IDLE);
  assign valid_o         = valid_q;
  assign err_o           = err_q;
  assign luma_hinc_o     = out_q[0];
  assign luma_vinc_o     = out_q[1];
  assign chroma_hinc_o   = out_q[2];
  assign chroma_vinc_o   = out_q[3];
  assign chroma_hstart_o = hst_q;
  assign chroma_vstart_o = vst_q;
  assign chroma_hphase_o = hst_q[FRAC_BITS-1 -: PHASE_BITS];
  assign chroma_vphase_o = vst_q[FRAC_BITS-1 -: PHASE_BITS];
endmodule

// File: rtl/scl_phase_calc_chk.sv
module scl_phase_calc_chk #(
  parameter int INC_W     = 16,
  parameter int START_W   = 16,
  parameter int FRAC_BITS = 13
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      start_i,
  input logic                      busy_o,
  input logic                      valid_o,
  input logic                      err_o,
  input logic [INC_W-1:0]          luma_hinc_o,
  input logic [INC_W-1:0]          luma_vinc_o,
  input logic [INC_W-1:0]          chroma_hinc_o,
  input logic [INC_W-1:0]          chroma_vinc_o,
  input logic signed [START_W-1:0] chroma_hstart_o,
  input logic signed [START_W-1:0] chroma_vstart_o
);
  localparam logic signed [START_W-1:0] QTR  = START_W'(1 << (FRAC_BITS - 2));
  localparam logic signed [START_W-1:0] HALF = START_W'(1 << (FRAC_BITS - 1));

  a_r8_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r8_busy_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (valid_o || err_o));

  a_r7_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(luma_hinc_o) && $stable(luma_vinc_o) &&
                  $stable(chroma_hinc_o) && $stable(chroma_vinc_o) &&
                  $stable(chroma_hstart_o) && $stable(chroma_vstart_o)));

  a_r10_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  a_r4_vstart_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chroma_vstart_o == '0) || (chroma_vstart_o == -QTR) || (chroma_vstart_o == -HALF));

  a_r5_hstart_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chroma_hstart_o == '0) || (chroma_hstart_o == -QTR));
endmodule

bind scl_phase_calc scl_phase_calc_chk #(
  .INC_W    (INC_W),
  .START_W  (START_W),
  .FRAC_BITS(FRAC_BITS)
) i_chk (.*);

// File: tb/test_scl_phase_calc.sv
`timescale 1ns/1ps
module test_scl_phase_calc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [11:0] src_w_i = '0, src_h_i = '0, dst_w_i = '0, dst_h_i = '0;
  logic [1:0]  src_fmt_i = '0, dst_fmt_i = '0;
  logic [2:0]  siting_i = '0;
  logic        busy_o, valid_o, err_o;
  logic [15:0] luma_hinc_o, luma_vinc_o, chroma_hinc_o, chroma_vinc_o;
  logic signed [15:0] chroma_hstart_o, chroma_vstart_o;
  logic [3:0]  chroma_hphase_o, chroma_vphase_o;

  int vectors = 0;
  int miscompares = 0;
  int last[6] = '{0, 0, 0, 0, 0, 0};

  always #4 clk_i = ~clk_i;

  scl_phase_calc i_scl_phase_calc (.*);

  task automatic chk(string req, string what, int got, int exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int exp_inc(int s, int d);
    longint q = ((longint'(s) <<< 13) + longint'(d / 2)) / longint'(d);
    return (q > 65535) ? 65535 : int'(q);
  endfunction

  function automatic int phase_of(int s);
    return (s & 8191) >> 9;
  endfunction

  task automatic out_now(output int o[6]);
    o[0] = int'(luma_hinc_o);
    o[1] = int'(luma_vinc_o);
    o[2] = int'(chroma_hinc_o);
    o[3] = int'(chroma_vinc_o);
    o[4] = int'(chroma_hstart_o);
    o[5] = int'(chroma_vstart_o);
  endtask

  task automatic kick(int sw, int sh, int dw, int dh, int sf, int df, int sit);
    @(negedge clk_i);
    src_w_i = 12'(sw); src_h_i = 12'(sh); dst_w_i = 12'(dw); dst_h_i = 12'(dh);
    src_fmt_i = 2'(sf); dst_fmt_i = 2'(df); siting_i = 3'(sit);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_end(output int n);
    n = 1;
    while (!valid_o && !err_o && n < 400) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic run(int sw, int sh, int dw, int dh, int sf, int df, int sit, bit busy_poke);
    int n;
    int o[6];
    int e[6];
    int scw, sch, dcw;
    bit zero;
    kick(sw, sh, dw, dh, sf, df, sit);
    if (busy_poke) begin
      repeat (10) @(negedge clk_i);
      src_w_i = 12'd4000; dst_w_i = 12'd3; src_fmt_i = 2'd0; siting_i = 3'd5;
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    wait_end(n);
    scw  = (sf == 0 || sf == 1) ? sw / 2 : sw;
    sch  = (sf == 0) ? sh / 2 : sh;
    dcw  = (df == 1) ? dw / 2 : dw;
    zero = (dw == 0) || (dh == 0) || (dcw == 0);
    out_now(o);
    if (zero) begin
      chk("R7", "err_o", int'(err_o), 1);
      chk("R7", "valid_o", int'(valid_o), 0);
      for (int k = 0; k < 6; k++) chk("R7", "held result", o[k], last[k]);
      @(negedge clk_i);
      chk("R7", "err_o held", int'(err_o), 1);
      return;
    end
    chk("R8", "valid_o seen", int'(valid_o), 1);
    chk("R8", "latency ok", int'(n <= 115), 1);
    chk("R8", "busy_o low at valid", int'(busy_o), 0);
    chk("R7", "err_o low", int'(err_o), 0);
    e[0] = exp_inc(sw, dw);
    e[1] = exp_inc(sh, dh);
    e[2] = exp_inc(scw, dcw);
    e[3] = exp_inc(sch, dh);
    e[4] = 0; e[5] = 0;
    if (sf == 0) begin
      if (sit == 0 || sit == 1) e[5] = -2048;
      if (sit == 4 || sit == 5) e[5] = -4096;
      if (sit == 1 || sit == 3 || sit == 5) e[4] = -2048;
    end
    chk(busy_poke ? "R10" : "R1", "luma_hinc", o[0], e[0]);
    chk(busy_poke ? "R10" : "R1", "luma_vinc", o[1], e[1]);
    chk("R3", "chroma_hinc", o[2], e[2]);
    chk("R3", "chroma_vinc", o[3], e[3]);
    chk("R5", "hstart", o[4], e[4]);
    chk("R4", "vstart", o[5], e[5]);
    chk("R6", "hphase", int'(chroma_hphase_o), phase_of(e[4]));
    chk("R6", "vphase", int'(chroma_vphase_o), phase_of(e[5]));
    for (int k = 0; k < 6; k++) last[k] = e[k];
    @(negedge clk_i);
    chk("R8", "valid_o single pulse", int'(valid_o), 0);
    repeat (3) @(negedge clk_i);
    out_now(o);
    for (int k = 0; k < 6; k++) chk("R9", "result hold", o[k], e[k]);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk("R11", "busy_o", int'(busy_o), 0);
    chk("R11", "valid_o", int'(valid_o), 0);
    chk("R11", "err_o", int'(err_o), 0);
    chk("R11", "luma_hinc", int'(luma_hinc_o), 0);
    chk("R11", "chroma_vstart", int'(chroma_vstart_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R1/R2 dimension sweep, 4:4:4 both ends
    begin
      int srcs[9] = '{1, 2, 3, 7, 8, 64, 100, 1920, 4095};
      int dsts[6] = '{1, 2, 5, 64, 720, 4095};
      for (int a = 0; a < 9; a++)
        for (int b = 0; b < 6; b++)
          run(srcs[a], srcs[8 - a] % 4000 + 1, dsts[b], dsts[5 - b], 2, 2, 0, 1'b0);
    end
    // R2 exact saturation threshold: 8/1 -> 65536, 7/1 -> 57344
    run(8, 7, 1, 1, 2, 2, 0, 1'b0);

    // R3/R4/R5 format and siting sweep, codes 3 and 6,7 included
    for (int sf = 0; sf < 4; sf++)
      for (int df = 0; df < 4; df++)
        for (int sit = 0; sit < 8; sit++)
          run(100 + sit * 37, 50 + sf * 21, 64 + df * 13, 31 + sit, sf, df, sit, 1'b0);

    // R7 zero divisors
    run(320, 240, 0, 100, 0, 2, 1, 1'b0);
    run(320, 240, 100, 0, 2, 2, 0, 1'b0);
    run(320, 240, 1, 100, 2, 1, 0, 1'b0);
    run(321, 241, 2, 3, 1, 1, 3, 1'b0);

    // R10 start while busy is ignored
    run(1280, 720, 1920, 1080, 0, 2, 4, 1'b1);
    run(17, 9, 5, 3, 0, 1, 5, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1_500_000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule